// File: doc/BRIEF.md
# Ready-Line Sleep Detector with Interrupt Wake

This block is glue logic for a small 8-bit processor whose ready line is bidirectional. Peripherals that need extra bus cycles each present an active-high "ready" request. The block merges them into a single ready drive, which reaches the processor's ready pin through an external series resistor. After the processor runs its wait-for-interrupt instruction, it pulls that same pin low itself. While it does, current flows through the resistor for as long as the block keeps driving high.

The block reads back the level at the pin and compares it with its own drive. If it drives high but sees low, the processor is holding the line. The block then records a sleep state. It drops its drive to remove the static current, and it shows the state on a `sleep` output for other power-saving logic. An active interrupt request, non-maskable interrupt or processor reset ends the sleep. The drive returns high in the same cycle in which the processor sees the wake condition.

The sensed level can pass through a configurable synchroniser (`SYNC_STAGES`, default 2) when the block runs on a clock other than the processor clock. The copy of the drive used for the comparison is delayed by the same number of stages, so the two inputs of the comparison stay aligned.

Top module: `rdy_sleep_ctl`

## Requirements
- R1: While awake, `rdy_drive` is 1 only when every bit of `dev_rdy_req` is 1. Any request at 0 makes it 0 in the same cycle.
- R2: A low line caused only by a device wait (the block's own drive is 0) never sets `sleep`.
- R3: If the line is held low while the block drives 1, `sleep` becomes 1 and `rdy_drive` becomes 0 exactly SYNC_STAGES+1 clock edges after the low level is first presented, and not one edge earlier.
- R4: Once asleep, `sleep` stays 1 and `rdy_drive` stays 0 whatever `dev_rdy_req` does, until a wake input goes active.
- R5: `irq_n` at 0 clears `sleep` at the next edge, and `rdy_drive` then returns to the device AND.
- R6: `nmi_n` at 0 clears `sleep` at the next edge in the same way.
- R7: `cpu_res_n` at 0 clears `sleep` at the next edge in the same way.
- R8: When a wake input is active in the same cycle as the set condition, the wake wins and `sleep` stays 0. Once the wake input goes inactive with the line still held, `sleep` sets at the next edge.
- R9: Block reset (`rst_n` at 0, asynchronous) forces `sleep` to 0, and `rdy_drive` then follows the device AND only.
- R10: After a wake, if the processor releases the line in the cycle the drive returns high, `sleep` does not set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (processor clock or a faster system clock) |
| rst_n | input | 1 | Asynchronous active-low block reset |
| dev_rdy_req | input | N_DEV | Per-device ready requests, 1 = no wait needed |
| line_sense | input | 1 | Level read back from the processor's ready pin |
| irq_n | input | 1 | Active-low interrupt request, wake source |
| nmi_n | input | 1 | Active-low non-maskable interrupt, wake source |
| cpu_res_n | input | 1 | Active-low processor reset, wake source |
| rdy_drive | output | 1 | Ready value driven onto the line through the resistor |
| sleep | output | 1 | 1 while the processor is in its wait state |

## Verification
A sleep flop stuck in the wrong state shows on both outputs at once. If it wrongly reads asleep, `rdy_drive` is 0 while every device request is high, and this is visible at the first sample. If it misses an entry, `sleep` is still 0 at the SYNC_STAGES+1 edge after the processor holds the line. A drive pipeline that is misaligned with the sensed path shows as `sleep` rising again a few cycles after a wake, or after a device wait ends. The bench therefore checks every cycle of each window, not only its end point.

// File: rtl/rdy_sleep_pkg.sv
package rdy_sleep_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } sleep_e;

  // Any active-low wake source asserted.
  function automatic logic any_wake(input logic irq_n, input logic nmi_n,
                                    input logic res_n);
    return !(irq_n & nmi_n & res_n);
  endfunction

  // Drive and sensed level disagree while the block is driving high:
  // someone else is pulling the line low.
  function automatic logic held_low(input logic drive, input logic sensed);
    return (drive ^ sensed) & drive;
  endfunction

endpackage

// File: rtl/rdy_req_merge.sv
module rdy_req_merge #(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV-1:0] req,
  output logic             all_ready
);
  assign all_ready = &req;
endmodule

// File: rtl/rdy_delay_line.sv
module rdy_delay_line #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d & ~flush;
    end else begin : g_regs
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh <= {STAGES{RST_VAL}};
        end else if (flush) begin
          sh <= '0;
        end else begin
          sh[0] <= d;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rdy_sleep_core.sv
module rdy_sleep_core
  import rdy_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_all,
  input  logic pin_s,
  input  logic drive_d,
  input  logic wake_req,
  output logic rdy_drive,
  output logic sleep,
  output logic set_ev,
  output logic clr_ev
);
  sleep_e st;

  assign set_ev = held_low(drive_d, pin_s);
  assign clr_ev = wake_req;

  // JK behaviour, clear has priority over set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= ST_AWAKE;
    else if (clr_ev) st <= ST_AWAKE;
    else if (set_ev) st <= ST_ASLEEP;
  end

  assign sleep     = (st == ST_ASLEEP);
  assign rdy_drive = dev_all & ~sleep;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> ($past(set_ev) && $past(rdy_drive)));

  // R8
  wake_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !sleep);

  // R4
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !clr_ev) |=> sleep);
endmodule

// File: rtl/rdy_sleep_ctl.sv
module rdy_sleep_ctl
  import rdy_sleep_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_rdy_req,
  input  logic             line_sense,
  input  logic             irq_n,
  input  logic             nmi_n,
  input  logic             cpu_res_n,
  output logic             rdy_drive,
  output logic             sleep
);
  logic dev_all, pin_s, drive_d, wake_ev, set_ev, clr_ev;

  assign wake_ev = any_wake(irq_n, nmi_n, cpu_res_n);

  rdy_req_merge #(.N_DEV(N_DEV)) u_merge (
    .req(dev_rdy_req), .all_ready(dev_all)
  );

  // Sensed pin: idle level is high.
  rdy_delay_line #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .d(line_sense), .q(pin_s)
  );

  // Own drive delayed to match, emptied while asleep so stale highs
  // cannot re-trigger right after a wake.
  rdy_delay_line #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_drv_dly (
    .clk(clk), .rst_n(rst_n), .flush(sleep), .d(rdy_drive), .q(drive_d)
  );

  rdy_sleep_core u_core (
    .clk(clk), .rst_n(rst_n), .dev_all(dev_all), .pin_s(pin_s),
    .drive_d(drive_d), .wake_req(wake_ev), .rdy_drive(rdy_drive),
    .sleep(sleep), .set_ev(set_ev), .clr_ev(clr_ev)
  );

  // R5 R6 R7: leaving sleep needs a wake source
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(wake_ev));
endmodule

// File: tb/sim_rdy_sleep_ctl.sv
module sim_rdy_sleep_ctl;
  localparam int N = 4;
  localparam int ST = 2;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] dev = ALL;
  logic hold = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, res_n = 1'b1;
  logic rdy, slp, line;

  always #4 clk = ~clk;  // 125 MHz

  // Processor pin model: pull through the resistor unless the CPU holds it.
  assign line = hold ? 1'b0 : rdy;

  rdy_sleep_ctl #(.N_DEV(N), .SYNC_STAGES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_rdy_req(dev), .line_sense(line),
    .irq_n(irq_n), .nmi_n(nmi_n), .cpu_res_n(res_n),
    .rdy_drive(rdy), .sleep(slp)
  );

  typedef struct {
    int    cyc;
    logic  s;
    logic  r;
    string tag;
  } exp_t;

  exp_t q[$];
  int cnt = 0, checks = 0, errors = 0;
  bit done = 0;

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    cnt++;
    #2;
    while (q.size() > 0 && q[0].cyc <= cnt) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cnt || slp !== e.s || rdy !== e.r) begin
        errors++;
        $display("FAIL %s cyc=%0d: sleep=%b rdy=%b expected sleep=%b rdy=%b",
                 e.tag, cnt, slp, rdy, e.s, e.r);
      end
    end
  end

  // Driver step: inputs already set at this falling edge; expect values
  // at the next sample, then move to the next falling edge.
  task automatic step(input logic s, input logic r, input string tag);
    exp_t e;
    e.cyc = cnt + 1; e.s = s; e.r = r; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic enter_sleep(input string tag);
    hold = 1'b1;
    for (int k = 0; k < ST; k++) step(1'b0, 1'b1, tag);
    step(1'b1, 1'b0, tag);
  endtask

  task automatic wake_and_check(input int src, input string tag);
    hold = 1'b0;  // processor releases the line as it sees the wake
    if (src == 0) irq_n = 1'b0;
    else if (src == 1) nmi_n = 1'b0;
    else res_n = 1'b0;
    step(1'b0, 1'b1, tag);
    irq_n = 1'b1; nmi_n = 1'b1; res_n = 1'b1;
    // R10: no false re-entry while the pipelines refill
    for (int k = 0; k < ST + 4; k++) step(1'b0, 1'b1, "R10");
  endtask

  initial begin
    @(negedge clk);
    hold = 1'b1;  // CPU holds the line during block reset
    // R9: reset state
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R9");
    hold = 1'b0; rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R9");

    // R1: AND of requests
    dev = 4'b1011; step(1'b0, 1'b0, "R1");
    dev = 4'b0111; step(1'b0, 1'b0, "R1");
    dev = ALL;     step(1'b0, 1'b1, "R1");

    // R2: long device wait, line low via own drive, then recovery
    dev = 4'b0000;
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, "R2");
    dev = ALL;
    for (int k = 0; k < ST + 3; k++) step(1'b0, 1'b1, "R2");

    // R3: entry latency
    enter_sleep("R3");

    // R4: device activity ignored while asleep
    dev = 4'b0101; step(1'b1, 1'b0, "R4");
    dev = ALL;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "R4");

    // R5: interrupt wake
    wake_and_check(0, "R5");

    // R6: non-maskable interrupt wake
    enter_sleep("R3");
    wake_and_check(1, "R6");

    // R7: processor reset wake
    enter_sleep("R3");
    wake_and_check(2, "R7");

    // R8: wake held while line held: stays awake, sets once released
    hold = 1'b1; irq_n = 1'b0;
    for (int k = 0; k < ST + 4; k++) step(1'b0, 1'b1, "R8");
    irq_n = 1'b1;
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");

    // R9: block reset while asleep
    rst_n = 1'b0; hold = 1'b0;
    step(1'b0, 1'b1, "R9");
    dev = 4'b1110; step(1'b0, 1'b0, "R9");
    rst_n = 1'b1; dev = ALL;
    for (int k = 0; k < ST + 2; k++) step(1'b0, 1'b1, "R9");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule